// File: doc/BRIEF.md
# Quadrature Carrier Correlator Downconverter

This block turns a directly sampled BPSK carrier into baseband. Real samples arrive at 250 kHz. The carrier is the 4 MHz reference divided by 76, about 52.63 kHz, so it has a period of 19 µs. A window of 19 consecutive samples spans exactly four carrier periods. The block correlates the newest 19 samples with one cosine reference and one sine reference, each spanning that same window. This moves the carrier component to DC. Each accepted sample produces one in-phase (I) value and one quadrature (Q) value.

The two sums need 38 multiply-accumulates per sample, 19 for I and 19 for Q. A single multiplier performs them one per clock. With a 16 MHz clock there are 64 clocks per sample, which leaves room to spare. Later stages are outside this block: the low-pass filter, phase correction and bit timing.

Top module: `qcar_corr`

## Requirements
- R1: While `rst_n` is low, and after it is released, `bb_valid`, `bb_i` and `bb_q` are all zero. Every stored sample in the window reads as zero.
- R2: The reference for tap k (k = 0..18) uses phase θk = 2π·4k/19. The I weight is round(2047·cos θk) and the Q weight is round(2047·sin θk), both signed 12-bit.
- R3: Tap 0 holds the newest accepted sample x0 and tap 18 holds the oldest. The I sum is Σ xk·Ik and the Q sum is Σ xk·Qk, both exact in a 29-bit signed accumulator.
- R4: Each output is the signed 16-bit value floor((sum + 4096) / 8192).
- R5: When a sample is accepted at clock edge c, and a result is due for it, `bb_valid` is high for exactly the one cycle after edge c+38.
- R6: The first 18 samples accepted after reset produce no `bb_valid`. The 19th accepted sample and every later one each produce one result.
- R7: A `smp_valid` is accepted when no computation is running, or when it arrives on the final (38th) computation edge of the previous sample. A strobe on any of the 37 edges after an accepted sample is ignored and does not enter the window.
- R8: `bb_i` and `bb_q` change only in a cycle where `bb_valid` is high. Otherwise they hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one multiply-accumulate per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new input sample |
| smp_data | input | 12 | Signed input sample |
| bb_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| bb_i | output | 16 | Signed in-phase result |
| bb_q | output | 16 | Signed quadrature result |

## Verification
Suppose a window entry is corrupted, or the window advances on a strobe that should have been dropped. The bad value then appears in the I and Q results for the next 19 accepted samples. Each of those results differs from the reference 38 cycles after its sample edge. A slip in the step counter has two possible effects. It moves `bb_valid` off its expected cycle, or it pairs taps with the wrong weights so that I or Q differs on the very next result. A wrong fill count shows up at the 19th sample after reset, as a strobe that comes too early or not at all.

// File: rtl/qcar_pkg.sv
package qcar_pkg;

   localparam real QCAR_PI = 3.14159265358979323846;

   // Reference weight for tap k: amplitude (2^(w-1)-1) times cos or sin of
   // 2*pi*cycles*k/taps, rounded to the nearest integer.
   function automatic int qcar_ref(input int k, input int taps, input int cycles,
                                   input int coef_w, input bit quad);
      real ph;
      real amp;
      ph  = 2.0 * QCAR_PI * real'((cycles * k) % taps) / real'(taps);
      amp = real'((1 << (coef_w - 1)) - 1);
      if (quad)
         return int'(amp * $sin(ph));
      else
         return int'(amp * $cos(ph));
   endfunction

endpackage

// File: rtl/qcar_delay_line.sv
module qcar_delay_line #(
   parameter int DATA_W = 12,
   parameter int TAPS   = 19,
   localparam int TAP_W = $clog2(TAPS),
   localparam int FILL_W = $clog2(TAPS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic signed [DATA_W-1:0] din,
   input  logic [TAP_W-1:0]         tap_sel,
   output logic signed [DATA_W-1:0] tap_out,
   output logic                     full_on_shift
);

   logic signed [DATA_W-1:0] line [TAPS];
   logic [FILL_W-1:0]        fill_cnt;

   for (genvar g = 0; g < TAPS; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        line[0] <= '0;
            else if (shift_en) line[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        line[g] <= '0;
            else if (shift_en) line[g] <= line[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_cnt <= '0;
      else if (shift_en && fill_cnt != FILL_W'(TAPS))
         fill_cnt <= fill_cnt + 1'b1;
   end

   assign full_on_shift = (fill_cnt >= FILL_W'(TAPS - 1));
   assign tap_out       = line[tap_sel];

endmodule

// File: rtl/qcar_coef_rom.sv
module qcar_coef_rom #(
   parameter int TAPS   = 19,
   parameter int CYCLES = 4,
   parameter int COEF_W = 12,
   localparam int TAP_W = $clog2(TAPS)
) (
   input  logic [TAP_W-1:0]         tap_sel,
   input  logic                     quad,
   output logic signed [COEF_W-1:0] coef
);

   logic signed [COEF_W-1:0] cos_tab [TAPS];
   logic signed [COEF_W-1:0] sin_tab [TAPS];

   for (genvar g = 0; g < TAPS; g++) begin : g_ref
      localparam int CV = qcar_pkg::qcar_ref(g, TAPS, CYCLES, COEF_W, 1'b0);
      localparam int SV = qcar_pkg::qcar_ref(g, TAPS, CYCLES, COEF_W, 1'b1);
      assign cos_tab[g] = COEF_W'(CV);
      assign sin_tab[g] = COEF_W'(SV);
   end

   assign coef = quad ? sin_tab[tap_sel] : cos_tab[tap_sel];

endmodule

// File: rtl/qcar_mac_seq.sv
module qcar_mac_seq #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 12,
   parameter int ACC_W  = 29,
   parameter int TAPS   = 19,
   localparam int TAP_W  = $clog2(TAPS),
   localparam int NSTEP  = 2 * TAPS,
   localparam int STEP_W = $clog2(NSTEP),
   localparam int PROD_W = DATA_W + COEF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic signed [DATA_W-1:0] sample,
   input  logic signed [COEF_W-1:0] coef,
   output logic [TAP_W-1:0]         tap_sel,
   output logic                     quad,
   output logic                     busy,
   output logic                     last,
   output logic signed [ACC_W-1:0]  fin_i,
   output logic signed [ACC_W-1:0]  fin_q
);

   logic [STEP_W-1:0]        step;
   logic                     running;
   logic signed [ACC_W-1:0]  acc_i;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [PROD_W-1:0] p_full;
   logic signed [ACC_W-1:0]  prod;

   assign p_full  = sample * coef;
   assign prod    = {{(ACC_W - PROD_W){p_full[PROD_W-1]}}, p_full};
   assign tap_sel = step[STEP_W-1:1];
   assign quad    = step[0];
   assign busy    = running;
   assign last    = running && (step == STEP_W'(NSTEP - 1));

   // The last step is always a Q step, so I is already complete then.
   assign fin_i = acc_i;
   assign fin_q = acc_q + prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         step    <= '0;
         acc_i   <= '0;
         acc_q   <= '0;
      end else if (start) begin
         running <= 1'b1;
         step    <= '0;
         acc_i   <= '0;
         acc_q   <= '0;
      end else if (running) begin
         step <= step + 1'b1;
         if (quad) acc_q <= acc_q + prod;
         else      acc_i <= acc_i + prod;
         if (last) running <= 1'b0;
      end
   end

endmodule

// File: rtl/qcar_corr.sv
module qcar_corr #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 12,
   parameter int ACC_W  = 29,
   parameter int OUT_W  = 16,
   parameter int TAPS   = 19,
   parameter int CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic              bb_valid,
   output logic [OUT_W-1:0]  bb_i,
   output logic [OUT_W-1:0]  bb_q
);

   localparam int TAP_W = $clog2(TAPS);
   localparam int SH    = ACC_W - OUT_W;

   if (TAPS < 2) begin : g_bad_taps
      $error("qcar_corr: TAPS must be at least 2");
   end
   if (CYCLES < 1 || CYCLES >= TAPS) begin : g_bad_cycles
      $error("qcar_corr: CYCLES must lie in 1..TAPS-1");
   end
   if (ACC_W < DATA_W + COEF_W + $clog2(TAPS)) begin : g_bad_acc
      $error("qcar_corr: ACC_W too narrow for the full sum");
   end
   if (OUT_W > ACC_W) begin : g_bad_out
      $error("qcar_corr: OUT_W exceeds ACC_W");
   end

   logic                     accept;
   logic                     busy;
   logic                     last;
   logic                     quad;
   logic                     full_on_shift;
   logic                     job_primed;
   logic [TAP_W-1:0]         tap_sel;
   logic signed [DATA_W-1:0] tap_val;
   logic signed [COEF_W-1:0] coef;
   logic signed [ACC_W-1:0]  fin_i;
   logic signed [ACC_W-1:0]  fin_q;
   logic [OUT_W-1:0]         rnd_i;
   logic [OUT_W-1:0]         rnd_q;

   assign accept = smp_valid && (!busy || last);

   qcar_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
      .clk           (clk),
      .rst_n         (rst_n),
      .shift_en      (accept),
      .din           (smp_data),
      .tap_sel       (tap_sel),
      .tap_out       (tap_val),
      .full_on_shift (full_on_shift)
   );

   qcar_coef_rom #(.TAPS(TAPS), .CYCLES(CYCLES), .COEF_W(COEF_W)) u_rom (
      .tap_sel (tap_sel),
      .quad    (quad),
      .coef    (coef)
   );

   qcar_mac_seq #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .TAPS(TAPS)) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .sample  (tap_val),
      .coef    (coef),
      .tap_sel (tap_sel),
      .quad    (quad),
      .busy    (busy),
      .last    (last),
      .fin_i   (fin_i),
      .fin_q   (fin_q)
   );

   if (SH == 0) begin : g_pass
      assign rnd_i = fin_i;
      assign rnd_q = fin_q;
   end else begin : g_round
      logic signed [ACC_W-1:0] half;
      logic signed [ACC_W-1:0] sum_i;
      logic signed [ACC_W-1:0] sum_q;
      assign half  = ACC_W'(1) << (SH - 1);
      assign sum_i = fin_i + half;
      assign sum_q = fin_q + half;
      assign rnd_i = sum_i[ACC_W-1:SH];
      assign rnd_q = sum_q[ACC_W-1:SH];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         job_primed <= 1'b0;
         bb_valid   <= 1'b0;
         bb_i       <= '0;
         bb_q       <= '0;
      end else begin
         if (accept) job_primed <= full_on_shift;
         bb_valid <= last && job_primed;
         if (last && job_primed) begin
            bb_i <= rnd_i;
            bb_q <= rnd_q;
         end
      end
   end

endmodule

// File: rtl/qcar_corr_chk.sv
module qcar_corr_chk #(
   parameter int TAPS  = 19,
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             bb_valid,
   input logic [OUT_W-1:0] bb_i,
   input logic [OUT_W-1:0] bb_q
);

   localparam int LAT    = 2 * TAPS;
   localparam int CNT_W  = $clog2(LAT + 1);
   localparam int FILL_W = $clog2(TAPS + 1);

   logic [CNT_W-1:0]  since;
   logic [CNT_W-1:0]  pend;
   logic [FILL_W-1:0] fill;
   logic              seen;
   logic              take;

   assign take = smp_valid && (!seen || since >= CNT_W'(LAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
         pend  <= '0;
         fill  <= '0;
         seen  <= 1'b0;
      end else begin
         if (take) begin
            seen  <= 1'b1;
            since <= '0;
            if (fill != FILL_W'(TAPS)) fill <= fill + 1'b1;
            pend  <= (fill >= FILL_W'(TAPS - 1)) ? CNT_W'(LAT) : '0;
         end else begin
            if (since != CNT_W'(LAT)) since <= since + 1'b1;
            if (pend != '0) pend <= pend - 1'b1;
         end
      end
   end

   // R5: strobe exactly LAT edges after an accepted, primed sample
   p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bb_valid == ($past(pend) == CNT_W'(1)));

   // R6: no strobe before the window has filled
   p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bb_valid |-> fill == FILL_W'(TAPS));

   // R7: accepted samples are spaced, so the strobe is a single cycle
   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bb_valid |=> !bb_valid);

   // R8: results hold between strobes
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bb_valid |-> ($stable(bb_i) && $stable(bb_q)));

endmodule

bind qcar_corr qcar_corr_chk #(.TAPS(TAPS), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .bb_valid  (bb_valid),
   .bb_i      (bb_i),
   .bb_q      (bb_q)
);

// File: tb/qcar_corr_test.sv
module qcar_corr_test;

   localparam int    CLK_PERIOD = 10;
   localparam int    TAPS       = 19;
   localparam int    LAT        = 38;
   localparam real   PI         = 3.14159265358979323846;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        bb_valid;
   logic [15:0] bb_i;
   logic [15:0] bb_q;

   qcar_corr uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .bb_valid  (bb_valid),
      .bb_i      (bb_i),
      .bb_q      (bb_q)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int     n_cmp = 0;
   int     n_bad = 0;
   bit     done = 1'b0;
   string  phase = "R1_reset";

   // reference state
   int     wi [TAPS];
   int     wq [TAPS];
   longint hist [TAPS];
   int     fill = 0;
   bit     have = 1'b0;
   longint last_acc = 0;
   longint cyc = 0;
   longint hold_i = 0;
   longint hold_q = 0;
   longint exp_t [$];
   longint exp_i [$];
   longint exp_q [$];

   logic   p_v = 1'b0;
   logic [11:0] p_d = '0;
   logic   p_rstn = 1'b0;
   bit     edge_seen = 1'b0;

   // R2: reference weights from the stated phase formula
   initial begin
      for (int k = 0; k < TAPS; k++) begin
         wi[k] = int'(2047.0 * $cos(2.0 * PI * 4.0 * real'(k) / 19.0));
         wq[k] = int'(2047.0 * $sin(2.0 * PI * 4.0 * real'(k) / 19.0));
         hist[k] = 0;
      end
   end

   always @(posedge clk) begin
      p_v       <= smp_valid;
      p_d       <= smp_data;
      p_rstn    <= rst_n;
      edge_seen <= 1'b1;
   end

   function automatic longint rnd16(input longint s);
      return (s + 4096) >>> 13;   // R4
   endfunction

   always @(negedge clk) begin
      if (edge_seen && !done) begin
         n_cmp++;
         if (!p_rstn) begin
            if (bb_valid !== 1'b0 || bb_i !== 16'd0 || bb_q !== 16'd0) begin
               n_bad++;
               $display("FAIL R1 (%s): valid=%b i=%0d q=%0d expected 0/0/0",
                        phase, bb_valid, bb_i, bb_q);
            end
            fill = 0; have = 1'b0; cyc = 0; hold_i = 0; hold_q = 0;
            for (int k = 0; k < TAPS; k++) hist[k] = 0;
            exp_t.delete(); exp_i.delete(); exp_q.delete();
         end else begin
            cyc++;
            // R7: acceptance rule
            if (p_v && (!have || cyc - last_acc >= LAT)) begin
               longint si;
               longint sq;
               for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
               hist[0] = longint'($signed(p_d));
               have = 1'b1;
               last_acc = cyc;
               if (fill < TAPS) fill++;
               if (fill == TAPS) begin   // R6
                  si = 0; sq = 0;
                  for (int k = 0; k < TAPS; k++) begin   // R3
                     si += hist[k] * wi[k];
                     sq += hist[k] * wq[k];
                  end
                  exp_t.push_back(cyc + LAT);            // R5
                  exp_i.push_back(rnd16(si));
                  exp_q.push_back(rnd16(sq));
               end
            end
            if (exp_t.size() > 0 && exp_t[0] == cyc) begin
               hold_i = exp_i[0];
               hold_q = exp_q[0];
               void'(exp_t.pop_front()); void'(exp_i.pop_front()); void'(exp_q.pop_front());
               if (bb_valid !== 1'b1) begin
                  n_bad++;
                  $display("FAIL R5/R6 (%s) cyc %0d: valid=%b expected 1", phase, cyc, bb_valid);
               end else if (longint'($signed(bb_i)) != hold_i || longint'($signed(bb_q)) != hold_q) begin
                  n_bad++;
                  $display("FAIL R3/R4 (%s) cyc %0d: i=%0d q=%0d expected i=%0d q=%0d",
                           phase, cyc, $signed(bb_i), $signed(bb_q), hold_i, hold_q);
               end
            end else begin
               if (bb_valid !== 1'b0) begin
                  n_bad++;
                  $display("FAIL R5/R6 (%s) cyc %0d: valid=%b expected 0", phase, cyc, bb_valid);
               end else if (longint'($signed(bb_i)) != hold_i || longint'($signed(bb_q)) != hold_q) begin
                  n_bad++;
                  $display("FAIL R8 (%s) cyc %0d: i=%0d q=%0d expected held i=%0d q=%0d",
                           phase, cyc, $signed(bb_i), $signed(bb_q), hold_i, hold_q);
               end
            end
         end
      end
   end

   task automatic drive(input logic v, input int d);
      smp_valid = v;
      smp_data  = d[11:0];
      @(negedge clk);
   endtask

   task automatic send(input int d, input int gap);
      drive(1'b1, d);
      for (int j = 1; j < gap; j++) drive(1'b0, 0);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (%s): run did not end, expected completion", phase);
      finish_run();
   end

   initial begin
      // R1: reset
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R6: 18 samples give nothing; the 19th and later produce results
      phase = "R6_fill";
      for (int n = 0; n < 22; n++) send(100 * n - 900, 40);

      // R2: matched cosine carrier, back-to-back spacing (R5)
      phase = "R2_cos_carrier";
      for (int n = 0; n < 40; n++)
         send(int'(1800.0 * $cos(2.0 * PI * 4.0 * real'(n) / 19.0)), LAT);

      phase = "R3_sin_carrier";
      for (int n = 0; n < 40; n++)
         send(int'(1500.0 * $sin(2.0 * PI * 4.0 * real'(n) / 19.0 + 0.7)), LAT);

      // R4: full-scale extremes
      phase = "R4_extremes";
      for (int n = 0; n < 25; n++) send((n % 2 == 0) ? -2048 : 2047, LAT);
      for (int n = 0; n < 20; n++) send(-2048, LAT);

      phase = "R3_random";
      for (int n = 0; n < 60; n++)
         send(int'($urandom_range(0, 4095)) - 2048, LAT + int'($urandom_range(0, 12)));

      // R7: strobes inside the busy window must be dropped
      phase = "R7_busy_drop";
      for (int n = 0; n < 30; n++) begin
         drive(1'b1, int'($urandom_range(0, 4095)) - 2048);
         for (int j = 1; j < LAT; j++)
            drive((j == 1 || j == LAT - 1 || $urandom_range(0, 3) == 0),
                  int'($urandom_range(0, 4095)) - 2048);
      end

      // R8: long idle, outputs must hold
      phase = "R8_idle";
      repeat (120) drive(1'b0, 0);
      finish_run();
   end

endmodule